// File: doc/BRIEF.md
# Sparse-Dense Rotate-Accumulate Multiplier

This block forms the product of a dense polynomial d(x) with P binary coefficients and a sparse polynomial s(x), reduced modulo x^P+1. The sparse operand arrives as a stream of set-bit positions. Each position turns into one pass over the result: the dense operand is rotated cyclically by that position and folded into a result memory, W coefficients per cycle. Two kinds of folding are selected at build time. In binary mode the fold is XOR and each result coefficient is one bit. In integer mode the fold is addition and each coefficient counts how many rotated copies have a one at that index.

Software or a neighbouring engine first writes the dense operand through a word-wide load port. It then pulses start and streams the positions with a valid/ready handshake, marking the final one with a last flag. Positions are dealt in turn to a configurable number of lanes. Each lane has its own position register and its own result memory, and all lanes of a group make their passes at the same time. When every pass has been written back, a one-cycle done pulse is raised. The product can then be read a word at a time: the read port merges the result memories of the lanes that took part.

Top module: `sparse_rot_mul`

## Requirements
- R1: In binary mode (BINARY=1), coefficient i of the result equals the XOR, over all streamed positions s, of dense coefficient (i - s) mod P.
- R2: In integer mode (BINARY=0), coefficient i is the integer count of streamed positions s for which dense coefficient (i - s) mod P is one. Each coefficient is K = clog2(VMAX+1) bits wide, so a list of up to VMAX distinct positions, all P of them included, is represented exactly.
- R3: Rotation wraps modulo P. Positions 0 and P-1 are both legal, and a result word that spans the wrap point takes its low-index coefficients from the top of the dense operand.
- R4: Every multiplication starts from a zero result. Nothing from an earlier product shows in a later one, including in lanes that receive no position in the later product.
- R5: Position n of a list, counting from 0, goes to lane n mod LANES. The lanes of a group run their passes together, and the read port combines the lanes that took part (by XOR in binary mode, by addition in integer mode).
- R6: pos_ready is high only while the block collects positions for a group. A position is taken on a cycle with pos_valid and pos_ready both high. A taken position with pos_last high closes the list, and pos_ready stays low from the next cycle until the next start.
- R7: done is a single-cycle pulse raised after the last pass has been written back, and pos_ready is low while it is high. Word j of the product is read by driving rd_addr = j; rd_data shows it two clock edges later, with coefficient k of the word in bits [k*CW +: CW] and coefficient index j*W + k.
- R8: Coefficient slots of the last word whose index is P or above read as zero.
- R9: While rst is high and on the first cycle after it falls, pos_ready and done are low and rd_data is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dload_en | input | 1 | Write one dense-operand word |
| dload_addr | input | AW | Dense word index; coefficient k of the word is index addr*W+k |
| dload_data | input | W | Dense coefficients, bit k is coefficient k of the word |
| start | input | 1 | Begin a multiplication (taken only when idle) |
| pos_valid | input | 1 | Position stream valid |
| pos_ready | output | 1 | Position stream ready |
| pos_data | input | PW | Set-bit position of the sparse operand, 0 to P-1 |
| pos_last | input | 1 | Marks the final position of the list |
| rd_addr | input | AW | Result word index to read |
| rd_data | output | W*CW | Result word, CW bits per coefficient |
| done | output | 1 | One-cycle pulse when the product is complete |

## Verification
Two things happen in the same cycle: a lane writes back the last word of one pass, and the controller takes the first position of the next group. The write-back also meets the read issued for the following word of the same pass. The bench provokes both with lists longer than the lane count, sent back to back, so that groups follow one another with no idle cycle between them. Every coefficient of every word, the padding slots included, is then compared with a rotate-and-sum model computed in the bench. A mixed-up word or a lost write-back therefore shows up as a coefficient mismatch that names the requirement.

// File: rtl/srm_pkg.sv
package srm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_COLLECT = 2'd1,
    ST_RUN     = 2'd2,
    ST_FLUSH   = 2'd3
  } srm_state_t;

  // bit width needed to index n items, at least one bit
  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/srm_ctrl.sv
module srm_ctrl
  import srm_pkg::*;
#(
  parameter int LANES = 3,
  parameter int NW    = 10,
  parameter int AW    = 4,
  parameter int LW    = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             pos_valid,
  input  logic             pos_last,
  output logic             pos_ready,
  output logic [LANES-1:0] lane_load,
  output logic [LANES-1:0] lane_go,
  output logic [AW-1:0]    word,
  output logic             last_word,
  output logic             clr,
  output logic             done
);

  srm_state_t       st_q;
  logic [LW-1:0]    fill_q;
  logic [LANES-1:0] loaded_q;
  logic             last_q;
  logic [AW-1:0]    word_q;
  logic             done_q;
  logic             take;
  logic             group_full;

  assign pos_ready  = (st_q == ST_COLLECT);
  assign take       = pos_ready && pos_valid;
  assign clr        = (st_q == ST_IDLE) && start;
  assign word       = word_q;
  assign last_word  = (word_q == AW'(NW - 1));
  assign group_full = (fill_q == LW'(LANES - 1));
  assign lane_go    = (st_q == ST_RUN) ? loaded_q : '0;
  assign done       = done_q;

  always_comb begin
    lane_load = '0;
    if (take) lane_load[fill_q] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      fill_q   <= '0;
      loaded_q <= '0;
      last_q   <= 1'b0;
      word_q   <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= (st_q == ST_FLUSH);
      case (st_q)
        ST_IDLE: begin
          if (start) begin
            st_q     <= ST_COLLECT;
            fill_q   <= '0;
            loaded_q <= '0;
          end
        end
        ST_COLLECT: begin
          if (take) begin
            loaded_q <= loaded_q | lane_load;
            fill_q   <= fill_q + LW'(1);
            last_q   <= pos_last;
            if (pos_last || group_full) begin
              st_q   <= ST_RUN;
              word_q <= '0;
            end
          end
        end
        ST_RUN: begin
          word_q <= word_q + AW'(1);
          if (last_word) begin
            loaded_q <= '0;
            fill_q   <= '0;
            st_q     <= last_q ? ST_FLUSH : ST_COLLECT;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/srm_lane.sv
module srm_lane #(
  parameter int P      = 37,
  parameter int W      = 4,
  parameter int CW     = 1,
  parameter bit BINARY = 1'b1,
  parameter int NW     = 10,
  parameter int AW     = 4,
  parameter int PW     = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic            load,
  input  logic [PW-1:0]   pos_in,
  input  logic            go,
  input  logic [AW-1:0]   word,
  input  logic            last_word,
  input  logic [AW-1:0]   rd_addr,
  input  logic [P-1:0]    dense,
  output logic            used,
  output logic [W*CW-1:0] q
);

  localparam int WB = W * CW;

  logic [PW-1:0] pos_q;
  logic          used_q;
  logic [W-1:0]  contrib;
  logic          s1_v;
  logic          s1_first;
  logic [AW-1:0] s1_addr;
  logic [W-1:0]  s1_c;
  logic [WB-1:0] q_r;
  logic [WB-1:0] wdata;
  logic [AW-1:0] ra;
  logic [WB-1:0] mem [NW];

  // gather the rotated dense coefficients for this word
  always_comb begin
    contrib = '0;
    for (int k = 0; k < W; k++) begin
      automatic int i = int'(word) * W + k;
      automatic int s = int'(pos_q);
      automatic int j = (i >= s) ? (i - s) : (i + P - s);
      if (i < P) contrib[k] = dense[PW'(j)];
    end
  end

  // fold the contribution into the word read one cycle earlier
  always_comb begin
    for (int k = 0; k < W; k++) begin
      automatic logic [CW-1:0] old = s1_first ? '0 : q_r[k*CW +: CW];
      wdata[k*CW +: CW] = BINARY ? (old ^ CW'(s1_c[k])) : (old + CW'(s1_c[k]));
    end
  end

  assign ra   = go ? word : rd_addr;
  assign q    = q_r;
  assign used = used_q;

  always_ff @(posedge clk) begin
    if (s1_v) mem[s1_addr] <= wdata;
    q_r <= mem[ra];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q    <= '0;
      used_q   <= 1'b0;
      s1_v     <= 1'b0;
      s1_first <= 1'b0;
      s1_addr  <= '0;
      s1_c     <= '0;
    end else begin
      if (load) pos_q <= pos_in;
      if (clr) used_q <= 1'b0;
      else if (go && last_word) used_q <= 1'b1;
      s1_v     <= go;
      s1_first <= !used_q;
      s1_addr  <= word;
      s1_c     <= contrib;
    end
  end

endmodule

// File: rtl/srm_reduce.sv
module srm_reduce #(
  parameter int LANES  = 3,
  parameter int W      = 4,
  parameter int CW     = 1,
  parameter bit BINARY = 1'b1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [LANES-1:0][W*CW-1:0] lane_q,
  input  logic [LANES-1:0]           used,
  output logic [W*CW-1:0]            rd_data
);

  logic [W*CW-1:0] sum;

  always_comb begin
    for (int k = 0; k < W; k++) begin
      automatic logic [CW-1:0] acc = '0;
      for (int l = 0; l < LANES; l++) begin
        if (used[l]) acc = BINARY ? (acc ^ lane_q[l][k*CW +: CW]) : (acc + lane_q[l][k*CW +: CW]);
      end
      sum[k*CW +: CW] = acc;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= sum;
  end

endmodule

// File: rtl/sparse_rot_mul.sv
module sparse_rot_mul
  import srm_pkg::*;
#(
  parameter int P      = 37,
  parameter int W      = 4,
  parameter int VMAX   = 8,
  parameter int LANES  = 3,
  parameter bit BINARY = 1'b1,
  localparam int NW    = (P + W - 1) / W,
  localparam int AW    = idx_width(NW),
  localparam int PW    = idx_width(P),
  localparam int K     = $clog2(VMAX + 1),
  localparam int CW    = BINARY ? 1 : K
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            dload_en,
  input  logic [AW-1:0]   dload_addr,
  input  logic [W-1:0]    dload_data,
  input  logic            start,
  input  logic            pos_valid,
  output logic            pos_ready,
  input  logic [PW-1:0]   pos_data,
  input  logic            pos_last,
  input  logic [AW-1:0]   rd_addr,
  output logic [W*CW-1:0] rd_data,
  output logic            done
);

  localparam int LW = idx_width(LANES);

  logic [P-1:0]              dense_q;
  logic [P-1:0]              dense_d;
  logic [LANES-1:0]          lane_load;
  logic [LANES-1:0]          lane_go;
  logic [LANES-1:0]          lane_used;
  logic [LANES-1:0][W*CW-1:0] lane_q;
  logic [AW-1:0]             word;
  logic                      last_word;
  logic                      clr;
  logic                      run_go;

  // dense operand: register file written a word at a time
  always_comb begin
    dense_d = dense_q;
    if (dload_en) begin
      for (int k = 0; k < W; k++) begin
        automatic int idx = int'(dload_addr) * W + k;
        if (idx < P) dense_d[PW'(idx)] = dload_data[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) dense_q <= '0;
    else     dense_q <= dense_d;
  end

  assign run_go = |lane_go;

  srm_ctrl #(.LANES(LANES), .NW(NW), .AW(AW), .LW(LW)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .pos_valid (pos_valid),
    .pos_last  (pos_last),
    .pos_ready (pos_ready),
    .lane_load (lane_load),
    .lane_go   (lane_go),
    .word      (word),
    .last_word (last_word),
    .clr       (clr),
    .done      (done)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    srm_lane #(.P(P), .W(W), .CW(CW), .BINARY(BINARY), .NW(NW), .AW(AW), .PW(PW)) u_lane (
      .clk       (clk),
      .rst       (rst),
      .clr       (clr),
      .load      (lane_load[l]),
      .pos_in    (pos_data),
      .go        (lane_go[l]),
      .word      (word),
      .last_word (last_word),
      .rd_addr   (rd_addr),
      .dense     (dense_q),
      .used      (lane_used[l]),
      .q         (lane_q[l])
    );
  end

  srm_reduce #(.LANES(LANES), .W(W), .CW(CW), .BINARY(BINARY)) u_reduce (
    .clk     (clk),
    .rst     (rst),
    .lane_q  (lane_q),
    .used    (lane_used),
    .rd_data (rd_data)
  );

endmodule

// File: rtl/srm_checker.sv
module srm_checker #(
  parameter int DW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          pos_valid,
  input logic          pos_ready,
  input logic          pos_last,
  input logic          done,
  input logic          run_go,
  input logic [DW-1:0] rd_data
);

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_not_ready_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> !pos_ready);

  assert_closed_after_last_R6: assert property (@(posedge clk) disable iff (rst)
    (pos_valid && pos_ready && pos_last) |=> !pos_ready);

  assert_not_ready_in_pass_R6: assert property (@(posedge clk) disable iff (rst)
    run_go |-> !pos_ready);

  assert_reset_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!pos_ready && !done && rd_data == '0));

endmodule

bind sparse_rot_mul srm_checker #(.DW(W*CW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .pos_valid (pos_valid),
  .pos_ready (pos_ready),
  .pos_last  (pos_last),
  .done      (done),
  .run_go    (run_go),
  .rd_data   (rd_data)
);

// File: tb/sim_sparse_rot_mul.sv
`timescale 1ns/1ps
module sim_sparse_rot_mul;

  localparam int P0 = 37;
  localparam int P1 = 7;
  localparam int WD = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld0 = 1'b0, ld1 = 1'b0;
  logic [3:0]  dload_addr = '0;
  logic [3:0]  dload_data = '0;
  logic        st0 = 1'b0, st1 = 1'b0;
  logic        pv0 = 1'b0, pv1 = 1'b0;
  logic [5:0]  pos_data = '0;
  logic        pos_last = 1'b0;
  logic [3:0]  rd_addr = '0;
  logic        rdy0, rdy1, done0, done1;
  logic [3:0]  rdat0;
  logic [11:0] rdat1;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  // binary mode, three lanes, 10 words
  sparse_rot_mul #(.P(P0), .W(WD), .VMAX(8), .LANES(3), .BINARY(1'b1)) u0 (
    .clk(clk), .rst(rst), .dload_en(ld0), .dload_addr(dload_addr), .dload_data(dload_data),
    .start(st0), .pos_valid(pv0), .pos_ready(rdy0), .pos_data(pos_data), .pos_last(pos_last),
    .rd_addr(rd_addr), .rd_data(rdat0), .done(done0));

  // integer mode, two lanes, 2 words, 3-bit coefficients
  sparse_rot_mul #(.P(P1), .W(WD), .VMAX(7), .LANES(2), .BINARY(1'b0)) u1 (
    .clk(clk), .rst(rst), .dload_en(ld1), .dload_addr(dload_addr[0:0]), .dload_data(dload_data),
    .start(st1), .pos_valid(pv1), .pos_ready(rdy1), .pos_data(pos_data[2:0]), .pos_last(pos_last),
    .rd_addr(rd_addr[0:0]), .rd_data(rdat1), .done(done1));

  // stimulus table: target instance, dense seed, list length, positions
  localparam int NC = 6;
  localparam int TSEL [NC] = '{0, 0, 0, 1, 1, 0};
  localparam int TSEED[NC] = '{11, 23, 37, 41, 59, 71};
  localparam int TCNT [NC] = '{3, 7, 1, 2, 7, 4};
  localparam int TPOS [NC][7] = '{
    '{0, 36, 17, 0, 0, 0, 0},
    '{5, 1, 36, 0, 22, 30, 11},
    '{36, 0, 0, 0, 0, 0, 0},
    '{0, 6, 0, 0, 0, 0, 0},
    '{0, 1, 2, 3, 4, 5, 6},
    '{3, 35, 36, 0, 0, 0, 0}
  };

  function automatic string tag_of(input int c);
    case (c)
      0: return "R1 R3";
      1: return "R5 R1";
      2: return "R4 R3";
      3: return "R2 R3";
      4: return "R2 R5";
      default: return "R5 R3";
    endcase
  endfunction

  function automatic logic [63:0] gen_dense(input int seed, input int p);
    logic [63:0] x;
    x = 64'h9E3779B97F4A7C15 ^ (64'(seed) << 17) ^ 64'(seed);
    for (int r = 0; r < 6; r++) begin
      x = x ^ (x << 13);
      x = x ^ (x >> 7);
      x = x ^ (x << 17);
    end
    return x & ((64'd1 << p) - 64'd1);
  endfunction

  function automatic int model(input logic [63:0] dv, input int p, input int c, input int i, input bit bin);
    int sum = 0;
    if (i >= p) return 0;
    for (int n = 0; n < TCNT[c]; n++) begin
      automatic int j = (i - TPOS[c][n] + p) % p;
      sum += int'(dv[j]);
    end
    return bin ? (sum % 2) : sum;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load_dense(input int sel, input logic [63:0] dv, input int nw);
    for (int w = 0; w < nw; w++) begin
      @(negedge clk);
      dload_addr = 4'(w);
      dload_data = dv[w*4 +: 4];
      ld0 = (sel == 0);
      ld1 = (sel == 1);
    end
    @(negedge clk);
    ld0 = 1'b0;
    ld1 = 1'b0;
  endtask

  task automatic wait_ready(input int sel);
    int guard = 0;
    while (!((sel == 0) ? rdy0 : rdy1) && guard < 1000) begin
      @(negedge clk);
      guard++;
    end
  endtask

  task automatic run_case(input int c);
    automatic int sel = TSEL[c];
    automatic int p   = (sel == 0) ? P0 : P1;
    automatic int nw  = (p + WD - 1) / WD;
    automatic logic [63:0] dv = gen_dense(TSEED[c], p);
    automatic int guard = 0;
    load_dense(sel, dv, nw);
    @(negedge clk);
    st0 = (sel == 0);
    st1 = (sel == 1);
    @(negedge clk);
    st0 = 1'b0;
    st1 = 1'b0;
    for (int n = 0; n < TCNT[c]; n++) begin
      pos_data = 6'(TPOS[c][n]);
      pos_last = (n == TCNT[c] - 1);
      pv0 = (sel == 0);
      pv1 = (sel == 1);
      wait_ready(sel);
      @(negedge clk);
    end
    pv0 = 1'b0;
    pv1 = 1'b0;
    pos_last = 1'b0;
    // R6: list closed, no more positions taken
    chk(((sel == 0) ? rdy0 : rdy1) == 1'b0, "R6 ready after last", 1, 0);
    while (!((sel == 0) ? done0 : done1) && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    chk(guard < 2000, "R7 done seen", guard, 0);
    @(negedge clk);
    chk(((sel == 0) ? done0 : done1) == 1'b0, "R7 done pulse width", 1, 0);
    for (int w = 0; w < nw; w++) begin
      rd_addr = 4'(w);
      @(negedge clk);
      @(negedge clk);
      for (int k = 0; k < WD; k++) begin
        automatic int i   = w * WD + k;
        automatic int exp = model(dv, p, c, i, sel == 0);
        automatic int act = (sel == 0) ? int'(rdat0[k]) : int'(rdat1[k*3 +: 3]);
        if (i >= p) chk(act == exp, "R8 padding slot", act, exp);
        else        chk(act == exp, tag_of(c), act, exp);
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: held in reset
    chk(!rdy0 && !rdy1, "R9 ready in reset", int'(rdy0 | rdy1), 0);
    chk(!done0 && !done1, "R9 done in reset", int'(done0 | done1), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(rdat0 == '0 && rdat1 == '0, "R9 read data after reset", int'(rdat0) + int'(rdat1), 0);
    chk(!rdy0 && !rdy1, "R9 ready after reset", int'(rdy0 | rdy1), 0);

    // table walk: each case loads, streams, waits and reads back
    for (int c = 0; c < NC; c++) run_case(c);

    // R4: repeat the large list, then a single position; the result must
    // carry nothing from the earlier product (lanes 1 and 2 stay unused)
    run_case(1);
    run_case(2);

    // R6: start ignored on the other instance; ready stays low when idle
    @(negedge clk);
    chk(!rdy0 && !rdy1, "R6 ready while idle", int'(rdy0 | rdy1), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule